// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Address Adapter

The adapter sits between a network peripheral with a 16-bit data path and a 32-bit-addressed memory port that moves one halfword per beat. The peripheral hands over a transfer request with a start address, a byte count, a direction flag and a bypass flag. The adapter combines the request address with a base value using a bitwise OR, not an addition. It then runs the transfer as a sequence of halfword beats on a request/ready memory interface.

In normal (swapping) mode the start address and the byte count are rounded down to even values. The two bytes of every halfword are exchanged in both directions. Writes to memory are cut into bursts of at most 64 bytes, with one idle cycle between bursts. In bypass mode address, count and data go through untouched, and an odd final byte is marked by a byte enable. Address translation and arbitration belong to other blocks.

Top module: `hswap_dma_adapter`

## Requirements
- R1: The first beat's memory address is `req_addr_i | base_i` (bit 0 cleared in swapping mode), and each accepted beat advances the address by 2, including across burst boundaries.
- R2: With `req_bypass_i` = 1, the address keeps bit 0. The beat count is ceil(len/2). Data passes unswapped in both directions, and when len is odd the final beat has `mem_be_o` = 2'b01 (bit 0 enables bits [7:0], the lower-addressed byte); every other beat has 2'b11.
- R3: With `req_bypass_i` = 0, bit 0 of the address and of the length is cleared before the transfer, so floor(len/2) beats are issued, all with `mem_be_o` = 2'b11.
- R4: In swapping mode a write to memory drives `mem_wdata_o` = {`pdat_wr_i[7:0]`, `pdat_wr_i[15:8]`}; `pdat_wr_take_o` pulses in each cycle a write beat is accepted.
- R5: In swapping mode a read beat presents `pdat_rd_o` = {`mem_rdata_i[7:0]`, `mem_rdata_i[15:8]`} with `pdat_rd_valid_o` high in the cycle the beat is accepted.
- R6: Swapping-mode writes are split into bursts of at most 64 bytes (32 beats): `mem_last_o` marks the final beat of each burst, and `mem_req_o` is low for exactly one cycle after a non-final burst ends.
- R7: Reads and bypass writes form a single burst; `mem_last_o` is high only on the final beat.
- R8: A request whose length is zero after alignment issues no memory beat and pulses `done_o` in the cycle after acceptance.
- R9: `done_o` is high for exactly one cycle, the cycle after the final beat is accepted, and `req_ready_o` returns high in the cycle after that.
- R10: A request is taken only while `req_ready_o` is high (idle); `req_valid_i` while busy has no effect on the transfer in progress.
- R11: While `mem_req_o` is high and `mem_ready_i` low, the request, address, byte enables and write data stay unchanged.
- R12: After reset `req_ready_o` = 1, `mem_req_o` = 0 and `done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | ADDR_W | Base value ORed into every request address |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Adapter idle, request taken this cycle |
| req_addr_i | input | ADDR_W | Transfer start address |
| req_len_i | input | LEN_W | Transfer length in bytes |
| req_write_i | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_bypass_i | input | 1 | 1: no alignment, no swap, no burst split |
| done_o | output | 1 | One-cycle completion pulse |
| pdat_wr_i | input | 16 | Halfword from the peripheral for a memory write |
| pdat_wr_take_o | output | 1 | Write halfword consumed this cycle |
| pdat_rd_o | output | 16 | Halfword to the peripheral from a memory read |
| pdat_rd_valid_o | output | 1 | Read halfword valid this cycle |
| mem_req_o | output | 1 | Memory beat request |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_be_o | output | 2 | Byte enables, bit 0 for bits [7:0] |
| mem_last_o | output | 1 | Final beat of a burst |
| mem_wdata_o | output | 16 | Write halfword |
| mem_rdata_i | input | 16 | Read halfword, valid with the accepted beat |

## Verification
The assertions check the cycle-level rules on every cycle: the even address in swapping mode, holding the beat stable during a stall, the step of 2 per accepted beat, the idle cycle after a burst boundary, the single-cycle done pulse and no memory request while idle. Only the bench scenarios can show the arithmetic over whole transfers. That covers the OR of base and address, the beat count for each length after alignment, where byte enables and burst ends fall, and the byte order of the data in each direction and mode. Those scenarios sweep every length through several burst boundaries in both directions and both modes, under an irregular ready pattern.

// File: rtl/hswap_pkg.sv
package hswap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int unsigned HW_BYTES = 2;
endpackage

// File: rtl/hswap_req_align.sv
module hswap_req_align #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              bypass_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [LEN_W-1:0]  byte_cnt_o,
  output logic              zero_o
);
  logic [ADDR_W-1:0] merged;

  always_comb begin
    merged = addr_i | base_i;
    if (bypass_i) begin
      start_addr_o = merged;
      byte_cnt_o   = len_i;
    end else begin
      start_addr_o = {merged[ADDR_W-1:1], 1'b0};
      byte_cnt_o   = {len_i[LEN_W-1:1], 1'b0};
    end
    zero_o = (byte_cnt_o == '0);
  end
endmodule

// File: rtl/hswap_lane_swap.sv
module hswap_lane_swap #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              bypass_i,
  input  logic [DATA_W-1:0] wr_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic [DATA_W-1:0] wr_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int unsigned NB = DATA_W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int unsigned SRC = NB - 1 - g;
    assign wr_o[8*g +: 8] = bypass_i ? wr_i[8*g +: 8] : wr_i[8*SRC +: 8];
    assign rd_o[8*g +: 8] = bypass_i ? rd_i[8*g +: 8] : rd_i[8*SRC +: 8];
  end
endmodule

// File: rtl/hswap_beat_seq.sv
module hswap_beat_seq
  import hswap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned CHUNK_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic              zero_i,
  input  logic              write_i,
  input  logic              bypass_i,
  input  logic              mem_ready_i,
  output logic              idle_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic              mem_last_o,
  output logic              beat_fire_o,
  output logic              write_o,
  output logic              bypass_o
);
  localparam int unsigned CHUNK_BEATS = CHUNK_BYTES / HW_BYTES;
  localparam int unsigned CB_W        = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1;
  localparam logic [CB_W-1:0] CB_LAST = CB_W'(CHUNK_BEATS - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CB_W-1:0]   cb_q, cb_d;
  logic              we_q, we_d;
  logic              byp_q, byp_d;

  logic last_beat, chunked, chunk_end, beat_fire;
  logic [LEN_W-1:0] step;

  always_comb begin
    last_beat = (rem_q <= LEN_W'(2));
    chunked   = we_q && !byp_q;
    chunk_end = chunked && (cb_q == CB_LAST) && !last_beat;
    beat_fire = (state_q == ST_XFER) && mem_ready_i;
    step      = (rem_q >= LEN_W'(2)) ? LEN_W'(2) : LEN_W'(1);
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cb_d    = cb_q;
    we_d    = we_q;
    byp_d   = byp_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        addr_d  = start_addr_i;
        rem_d   = byte_cnt_i;
        cb_d    = '0;
        we_d    = write_i;
        byp_d   = bypass_i;
        state_d = zero_i ? ST_DONE : ST_XFER;
      end
      ST_XFER: if (beat_fire) begin
        addr_d = addr_q + ADDR_W'(HW_BYTES);
        rem_d  = rem_q - step;
        if (last_beat) begin
          state_d = ST_DONE;
        end else if (chunk_end) begin
          state_d = ST_GAP;
          cb_d    = '0;
        end else begin
          cb_d = cb_q + CB_W'(1);
        end
      end
      ST_GAP:  state_d = ST_XFER;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cb_q    <= '0;
      we_q    <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cb_q    <= cb_d;
      we_q    <= we_d;
      byp_q   <= byp_d;
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_XFER);
  assign mem_addr_o  = addr_q;
  assign mem_be_o    = (byp_q && rem_q == LEN_W'(1)) ? 2'b01 : 2'b11;
  assign mem_last_o  = mem_req_o && (last_beat || chunk_end);
  assign beat_fire_o = beat_fire;
  assign write_o     = we_q;
  assign bypass_o    = byp_q;

  // R1
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_fire && !last_beat) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(HW_BYTES)));

  // R6
  chunk_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_fire && chunk_end) |=> (!mem_req_o ##1 mem_req_o));
endmodule

// File: rtl/hswap_dma_adapter.sv
module hswap_dma_adapter #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned CHUNK_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_write_i,
  input  logic              req_bypass_i,
  output logic              done_o,
  input  logic [15:0]       pdat_wr_i,
  output logic              pdat_wr_take_o,
  output logic [15:0]       pdat_rd_o,
  output logic              pdat_rd_valid_o,
  output logic              mem_req_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic              mem_last_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  byte_cnt;
  logic              zero_len;
  logic              idle, beat_fire, we_q, byp_q, start;

  assign start = req_valid_i && idle;

  hswap_req_align #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_align (
    .addr_i      (req_addr_i),
    .base_i      (base_i),
    .len_i       (req_len_i),
    .bypass_i    (req_bypass_i),
    .start_addr_o(start_addr),
    .byte_cnt_o  (byte_cnt),
    .zero_o      (zero_len)
  );

  hswap_beat_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_addr_i(start_addr),
    .byte_cnt_i  (byte_cnt),
    .zero_i      (zero_len),
    .write_i     (req_write_i),
    .bypass_i    (req_bypass_i),
    .mem_ready_i (mem_ready_i),
    .idle_o      (idle),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_last_o  (mem_last_o),
    .beat_fire_o (beat_fire),
    .write_o     (we_q),
    .bypass_o    (byp_q)
  );

  hswap_lane_swap #(.DATA_W(16)) i_swap (
    .bypass_i(byp_q),
    .wr_i    (pdat_wr_i),
    .rd_i    (mem_rdata_i),
    .wr_o    (mem_wdata_o),
    .rd_o    (pdat_rd_o)
  );

  assign req_ready_o     = idle;
  assign mem_we_o        = we_q;
  assign pdat_wr_take_o  = beat_fire && we_q;
  assign pdat_rd_valid_o = beat_fire && !we_q;

  // R3
  addr_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !byp_q) |-> (mem_addr_o[0] == 1'b0));

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !done_o));
endmodule

// File: tb/test_hswap_dma_adapter.sv
`timescale 1ns/1ps
module test_hswap_dma_adapter;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int CHUNK_BEATS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_write = 1'b0;
  logic          req_bypass = 1'b0;
  logic          done;
  logic [15:0]   pwr = '0;
  logic          pwr_take;
  logic [15:0]   prd;
  logic          prd_valid;
  logic          mreq;
  logic          mready = 1'b0;
  logic          mwe;
  logic [AW-1:0] maddr;
  logic [1:0]    mbe;
  logic          mlast;
  logic [15:0]   mwdata;
  logic [15:0]   mrdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hswap_dma_adapter i_hswap_dma_adapter (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_write_i(req_write), .req_bypass_i(req_bypass),
    .done_o(done), .pdat_wr_i(pwr), .pdat_wr_take_o(pwr_take),
    .pdat_rd_o(prd), .pdat_rd_valid_o(prd_valid),
    .mem_req_o(mreq), .mem_ready_i(mready), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_be_o(mbe), .mem_last_o(mlast), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  task automatic do_xfer(input logic [AW-1:0] a, input int len, input bit wr,
                         input bit byp, input bit poke);
    logic [AW-1:0] start;
    int nbytes, beats, k, tmo;
    bit chunked, gap_exp, fin;
    logic [15:0] wpat, rpat;
    start   = byp ? (a | base) : ((a | base) & ~AW'(1));
    nbytes  = byp ? len : (len & ~1);
    beats   = (nbytes + 1) / 2;
    chunked = wr && !byp;

    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_len = LW'(len);
    req_write = wr; req_bypass = byp; mready = 1'b0;
    @(negedge clk);
    req_valid = poke; req_addr = ~a; req_len = LW'(len + 7);
    req_write = ~wr; req_bypass = ~byp;
    k = 0; tmo = 0; gap_exp = 0; fin = (beats == 0);
    while (!fin && tmo < 2000) begin
      cyc++;
      mready = ((cyc * 7 + len) % 5) != 0;
      wpat   = 16'(16'hC300 ^ (k * 16'h0113) ^ len);
      rpat   = 16'(16'h5A0F ^ (k * 16'h0301) ^ (len << 4));
      pwr    = wpat; mrdata = rpat;
      #1;
      chk(done == 1'b0, "R9 no early done", 64'(done), 64'd0);
      if (poke) chk(req_ready == 1'b0, "R10 busy not ready", 64'(req_ready), 64'd0);
      if (gap_exp) begin
        chk(mreq == 1'b0, "R6 idle cycle between bursts", 64'(mreq), 64'd0);
        gap_exp = 0;
      end else begin
        bit elast, ebody;
        logic [1:0] ebe;
        elast = (k == beats - 1) || (chunked && (k % CHUNK_BEATS) == CHUNK_BEATS - 1);
        ebe   = (byp && (nbytes % 2 == 1) && k == beats - 1) ? 2'b01 : 2'b11;
        chk(mreq == 1'b1, "R11 request held", 64'(mreq), 64'd1);
        chk(maddr == start + AW'(2 * k), "R1 beat address", 64'(maddr), 64'(start + AW'(2 * k)));
        chk(mwe == wr, "R1 direction", 64'(mwe), 64'(wr));
        chk(mbe == ebe, byp ? "R2 byte enables" : "R3 byte enables", 64'(mbe), 64'(ebe));
        chk(mlast == elast, chunked ? "R6 burst end" : "R7 single burst end", 64'(mlast), 64'(elast));
        if (wr) begin
          chk(mwdata == (byp ? wpat : sw(wpat)), byp ? "R2 write data" : "R4 write swap",
              64'(mwdata), 64'(byp ? wpat : sw(wpat)));
          chk(pwr_take == mready, "R4 write take", 64'(pwr_take), 64'(mready));
        end else begin
          chk(prd_valid == mready, "R5 read valid", 64'(prd_valid), 64'(mready));
          if (mready)
            chk(prd == (byp ? rpat : sw(rpat)), byp ? "R2 read data" : "R5 read swap",
                64'(prd), 64'(byp ? rpat : sw(rpat)));
        end
        ebody = (k != beats - 1) && elast;
        if (mready) begin
          k++;
          if (ebody) gap_exp = 1;
          if (k == beats) fin = 1;
        end
      end
      @(negedge clk);
      tmo++;
    end
    if (tmo >= 2000) chk(1'b0, "R9 transfer timeout", 64'(k), 64'(beats));
    req_valid = 1'b0; mready = 1'b0;
    #1;
    chk(done == 1'b1, (beats == 0) ? "R8 zero length done" : "R9 done after final beat",
        64'(done), 64'd1);
    chk(mreq == 1'b0, (beats == 0) ? "R8 no beats" : "R9 no beat at done", 64'(mreq), 64'd0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R9 single pulse then ready",
        64'({done, req_ready}), 64'b01);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk(req_ready == 1'b1 && mreq == 1'b0 && done == 1'b0, "R12 reset state",
        64'({req_ready, mreq, done}), 64'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mreq == 1'b0 && done == 1'b0, "R12 after reset release",
        64'({req_ready, mreq, done}), 64'b100);

    base = 32'h00A0_0031;
    for (int l = 0; l <= 135; l++) do_xfer(32'h0000_1204, l, 1'b1, 1'b0, l[0]);
    for (int l = 0; l <= 70; l++)  do_xfer(32'h0000_0203, l, 1'b0, 1'b0, l[1]);
    for (int l = 0; l <= 70; l++)  do_xfer(32'h0000_0103, l, 1'b1, 1'b1, l[0]);
    for (int l = 0; l <= 40; l++)  do_xfer(32'h0000_0046, l, 1'b0, 1'b1, 1'b1);
    base = 32'h0000_0000;
    do_xfer(32'h1000_0001, 129, 1'b1, 1'b0, 1'b1);
    do_xfer(32'h1000_0FFF, 200, 1'b1, 1'b1, 1'b0);
    base = 32'hFFFF_0000;
    do_xfer(32'h0000_0FF0, 66, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule